// File: doc/BRIEF.md
# Serial-in shift register with latched parallel outputs

This block turns a serial bit stream into a parallel word. It has two register banks. A shift chain takes one new bit into position 0 on every rising edge of its shift clock. A holding bank copies the whole chain on a rising edge of a separate storage clock, and that copy drives the parallel outputs. So the outputs stay steady while the next word is shifted in, and they all change together when software or a controller strobes the storage clock.

Each bank has its own active-low clear. A clear takes effect as soon as it falls. When it is released, it passes through a short synchronizer in the bank's own clock domain. The last chain position is also brought out as a serial output, so several units can be chained into a longer converter. The width is a parameter `W`, with a default of 8 and a minimum of 2.

Top module: `shift_latch_reg`

## Requirements
- R1: On each rising `sh_clk` edge while the shift bank is active, `ser_in` is captured into position 0 and every position k>0 takes the old value of position k-1.
- R2: `ser_out` always equals chain position W-1. After one shift, it shows what position W-2 held before that shift.
- R3: On each rising `st_clk` edge while the holding bank is active, the holding bank takes the chain contents, and `par_out[n]` equals chain position n. Bit 0 is the newest bit shifted in and bit W-1 is the oldest.
- R4: While `sh_clr_n` is low, the chain is all zeros and `ser_out` is 0. `par_out` keeps its value.
- R5: While `st_clr_n` is low, `par_out` is all zeros. The chain keeps shifting and keeps its contents, and these become visible on the next storage load.
- R6: A rising `st_clk` edge that arrives while the shift bank is held cleared loads all zeros into `par_out`.
- R7: When `sh_clk` and `st_clk` rise together, the holding bank captures the chain as it was before that edge, so `par_out` lags the chain by exactly one pulse.
- R8: A clear acts immediately when it falls. After it is released, the first two rising edges of that bank's own clock leave the bank cleared, and the bank works normally from the third edge on.
- R9: A clock edge that arrives while a bank's clear is low has no effect on that bank. A 1 on `ser_in` during that edge is not captured.
- R10: When `ser_out` of one unit drives `ser_in` of a second unit, 2W shifts followed by one storage load present the whole 2W-bit stream in order: the second unit's `par_out` holds the first W bits and the first unit's `par_out` holds the last W bits, with the earliest bit at the top of the second unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sh_clk | input | 1 | Shift clock; the chain moves on its rising edge |
| sh_clr_n | input | 1 | Active-low clear for the shift chain |
| st_clk | input | 1 | Storage clock; the holding bank loads on its rising edge |
| st_clr_n | input | 1 | Active-low clear for the holding bank |
| ser_in | input | 1 | Serial data into chain position 0 |
| ser_out | output | 1 | Last chain position, used for chaining units |
| par_out | output | W | Holding-bank contents; bit n comes from chain position n |

## Verification
`ser_out` and `par_out` settle in the same step as the rising edge of their own clock, so the bench makes each clock pulse one 5 ns step. It drives `ser_in` 1 ns before the edge and samples 2 ns after it. A falling clear is checked 1 ns after it falls, with no clock involved. A release is checked over the two following edges of that clock, which must still show zeros, and then on the third edge, which must show data. The behavioural model counts those pending edges for each bank. It updates both banks from their values before the edge, which is what produces the one-pulse lag when the two clocks are tied together.

// File: rtl/shift_latch_reg.sv
module shift_latch_reg #(
  parameter int W          = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic         sh_clk,
  input  logic         sh_clr_n,
  input  logic         st_clk,
  input  logic         st_clr_n,
  input  logic         ser_in,
  output logic         ser_out,
  output logic [W-1:0] par_out
);

  localparam int TOP = W - 1;

  logic [SYNC_DEPTH-1:0] sh_sync, st_sync;
  logic                  sh_live, st_live;
  logic [W-1:0]          chain, hold;

  always_ff @(posedge sh_clk or negedge sh_clr_n)
    if (!sh_clr_n) sh_sync <= '0;
    else           sh_sync <= {sh_sync[SYNC_DEPTH-2:0], 1'b1};

  always_ff @(posedge st_clk or negedge st_clr_n)
    if (!st_clr_n) st_sync <= '0;
    else           st_sync <= {st_sync[SYNC_DEPTH-2:0], 1'b1};

  assign sh_live = sh_sync[SYNC_DEPTH-1];
  assign st_live = st_sync[SYNC_DEPTH-1];

  always_ff @(posedge sh_clk or negedge sh_live)
    if (!sh_live) chain <= '0;
    else          chain <= {chain[TOP-1:0], ser_in};

  always_ff @(posedge st_clk or negedge st_live)
    if (!st_live) hold <= '0;
    else          hold <= chain;

  assign ser_out = chain[TOP];
  assign par_out = hold;

  AST_SHIFT_MOVE: assert property (@(posedge sh_clk) disable iff (!sh_live)
    chain[TOP:1] == $past(chain[TOP-1:0])); // R1

  AST_STORE_COPY: assert property (@(posedge st_clk) disable iff (!st_live)
    1'b1 |=> par_out == $past(chain)); // R3

  AST_ZERO_LOAD: assert property (@(posedge st_clk) disable iff (!st_live)
    !sh_live |=> par_out == '0); // R6

  AST_HOLD_CLEARED: assert property (@(posedge st_clk)
    !st_live |-> par_out == '0); // R5

endmodule

// File: tb/tb_shift_latch_reg.sv
module tb_shift_latch_reg;
  localparam int W = 8;

  logic sh_clk = 0, st_clk = 0, sh_clr_n = 1, st_clr_n = 1, ser_in = 0;
  logic         ser_lo, ser_hi;
  logic [W-1:0] par_lo, par_hi;

  shift_latch_reg #(.W(W)) dut (.sh_clk(sh_clk), .sh_clr_n(sh_clr_n), .st_clk(st_clk),
    .st_clr_n(st_clr_n), .ser_in(ser_in), .ser_out(ser_lo), .par_out(par_lo));
  shift_latch_reg #(.W(W)) dut_hi (.sh_clk(sh_clk), .sh_clr_n(sh_clr_n), .st_clk(st_clk),
    .st_clr_n(st_clr_n), .ser_in(ser_lo), .ser_out(ser_hi), .par_out(par_hi));

  int total = 0, bad = 0;
  string req = "R8";
  bit [W-1:0] m_lo, m_hi, m_st_lo, m_st_hi;
  int sh_wait = 2, st_wait = 2;

  task automatic chk(string what, logic [2*W-1:0] got, logic [2*W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic compare_all();
    chk("par_out", {{W{1'b0}}, par_lo}, {{W{1'b0}}, m_st_lo});
    chk("ser_out", {{(2*W-1){1'b0}}, ser_lo}, {{(2*W-1){1'b0}}, m_lo[W-1]});
    chk("chained par_out", {{W{1'b0}}, par_hi}, {{W{1'b0}}, m_st_hi});
  endtask

  task automatic step(bit dsh, bit dst, bit din);
    bit [W-1:0] o_lo, o_hi;
    o_lo = m_lo; o_hi = m_hi;
    ser_in = din;
    #1;
    sh_clk = dsh; st_clk = dst;
    if (dsh && sh_clr_n) begin
      if (sh_wait > 0) sh_wait--;
      else begin m_lo = {o_lo[W-2:0], din}; m_hi = {o_hi[W-2:0], o_lo[W-1]}; end
    end
    if (dst && st_clr_n) begin
      if (st_wait > 0) st_wait--;
      else begin m_st_lo = o_lo; m_st_hi = o_hi; end
    end
    #2;
    compare_all();
    sh_clk = 0; st_clk = 0;
    #2;
  endtask

  task automatic set_sh_clr(bit v);
    sh_clr_n = v;
    if (!v) begin m_lo = '0; m_hi = '0; sh_wait = 2; end
    #1; compare_all();
  endtask

  task automatic set_st_clr(bit v);
    st_clr_n = v;
    if (!v) begin m_st_lo = '0; m_st_hi = '0; st_wait = 2; end
    #1; compare_all();
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    bit [2*W-1:0] stream_exp;
    bit [7:0] pat;
    #1;
    req = "R8";
    set_sh_clr(0); set_st_clr(0);
    chk("reset par_out", {{W{1'b0}}, par_lo}, '0);
    set_sh_clr(1); set_st_clr(1);
    step(1, 1, 1); step(1, 1, 1);
    chk("R8 still cleared after two edges", {{W{1'b0}}, par_lo}, '0);
    step(1, 0, 1);
    chk("R8 third edge captures", {{(2*W-1){1'b0}}, ser_lo}, '0);

    req = "R1";
    pat = 8'b1011_0010;
    for (int i = 7; i >= 0; i--) step(1, 0, pat[i]);
    req = "R2";
    step(1, 0, 0);
    req = "R3";
    step(0, 1, 0);
    chk("R3 bit order", {{W{1'b0}}, par_lo}, {{W{1'b0}}, m_lo});
    pat = 8'b0110_1001;
    req = "R1";
    for (int i = 7; i >= 0; i--) step(1, 0, pat[i]);
    req = "R3";
    step(0, 1, 0);

    req = "R7";
    for (int i = 0; i < 6; i++) step(1, 1, i[0]);

    req = "R4";
    set_sh_clr(0);
    chk("R4 ser_out low", {{(2*W-1){1'b0}}, ser_lo}, '0);
    req = "R9";
    step(1, 0, 1);
    step(1, 0, 1);
    req = "R6";
    step(0, 1, 0);
    chk("R6 zero load", {{W{1'b0}}, par_lo}, '0);
    req = "R8";
    set_sh_clr(1);
    step(1, 0, 1); step(1, 0, 1); step(1, 0, 1); step(1, 0, 0);

    req = "R5";
    step(0, 1, 0);
    set_st_clr(0);
    for (int i = 0; i < 3; i++) step(1, 0, 1);
    req = "R9";
    step(0, 1, 0);
    req = "R5";
    set_st_clr(1);
    step(0, 1, 0); step(0, 1, 0);
    step(0, 1, 0);
    chk("R5 chain survived", {{W{1'b0}}, par_lo}, {{W{1'b0}}, m_lo});

    req = "R10";
    stream_exp = '0;
    for (int i = 0; i < 2*W; i++) begin
      bit b;
      b = ((i * 7) % 5) < 2;
      stream_exp = {stream_exp[2*W-2:0], b};
      step(1, 0, b);
    end
    step(0, 1, 0);
    chk("R10 chained stream", {par_hi, par_lo}, stream_exp);

    finish_run();
  end
endmodule